// File: doc/BRIEF.md
# Serial EEPROM Bus Slave Front End

This block is the two-wire bus side of a 2048-byte serial memory. It watches the clock and data lines, finds START and STOP conditions, and assembles bytes with the most significant bit first. Each command byte is checked against three strapped select pins. The block then either loads an address and passes received data bytes to the memory side, or fetches bytes from the memory side and shifts them out on the open-drain data line. An 11-bit address counter sits between the two directions. A random read, a current-address read and a sequential read all use this counter.

Both bus lines are sampled in the system clock domain through a synchronizer. The block drives the data line only as a pull-down enable. A write byte appears on the memory side as a one-cycle strobe with its address. A read is a request strobe with an address, answered by an acknowledge strobe that carries the data. A commit strobe marks the STOP that ends a transfer in which data was accepted. While the programming logic reports busy, the block refuses every command byte. A master can therefore poll for the end of a programming cycle.

Top module: `ee_i2c_slave`

## Requirements
- R1: During and right after reset, the pull-down is released and no write, read or commit strobe is active. The address counter starts at 0, so a current-address read first returns location 0.
- R2: A command byte is acknowledged (data held low through the ninth clock) only if bit 7 is 1 and bits 6..4 equal `chip_sel_i`. Otherwise the block releases the data line and ignores all following bytes until the next START.
- R3: While `busy_i` is high, a matching command byte is not acknowledged, whatever its direction bit 0 (0 = write, 1 = read).
- R4: In a write command byte, bits 3..1 become address bits 10..8. The next byte, also acknowledged, supplies address bits 7..0.
- R5: Each data byte after the address byte is acknowledged and produces exactly one `wr_valid_o` pulse carrying the counter value and the byte. The counter then advances in its low 4 bits only, wrapping inside the 16-byte page.
- R6: `commit_o` pulses once at a STOP when at least one complete data byte has been accepted since the last START. A STOP after only an address byte, or a START that ends a write, gives no commit.
- R7: In a read, each byte is shifted out MSB first from the location the counter holds, and the counter increments per byte. Another byte follows when the master acknowledges. After a master NACK the data line stays released.
- R8: A write command and address byte, then a repeated START and a read command, reads from that address. A read command with no address reads from the current counter value.
- R9: A sequential read passes from address 2047 to address 0.
- R10: A START or STOP in the middle of a byte discards the partial byte and restarts bit counting. A command byte that follows is decoded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired value) |
| sda_oe_o | output | 1 | 1 = pull data line low |
| chip_sel_i | input | 3 | Strapped device select bits |
| busy_i | input | 1 | Programming cycle in progress |
| wr_valid_o | output | 1 | One-cycle write data strobe |
| wr_addr_o | output | 11 | Address of the write byte |
| wr_data_o | output | 8 | Write byte |
| commit_o | output | 1 | One-cycle strobe at a STOP ending a write with data |
| rd_req_o | output | 1 | One-cycle read request |
| rd_addr_o | output | 11 | Read request address |
| rd_ack_i | input | 1 | Read data return strobe |
| rd_data_i | input | 8 | Read data |

## Verification
A wrong bit count or state shows at the pins within one byte time. The acknowledge then lands in the wrong slot, or a read byte comes out shifted. A counter fault stays hidden until the next data byte, where a write strobe or a read request carries the wrong address. A page that wraps wrongly, or a read that does not roll over, shows only at those addresses. For that reason the bench drives transfers that start near a page end and near the top of the array.

// File: rtl/ee_i2c_pkg.sv
package ee_i2c_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_ADDR,
    PH_WDATA,
    PH_RDATA,
    PH_ACK,
    PH_MACK,
    PH_SKIP
  } phase_t;

  localparam int BYTE_BITS = 8;
endpackage

// File: rtl/ee_i2c_linecond.sv
module ee_i2c_linecond #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_p;
  logic [STAGES-1:0] sda_p;
  logic scl_q;
  logic sda_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_p <= 1'b1;
          sda_p <= 1'b1;
        end else begin
          scl_p <= scl_i;
          sda_p <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_p <= '1;
          sda_p <= '1;
        end else begin
          scl_p <= {scl_p[STAGES-2:0], scl_i};
          sda_p <= {sda_p[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_p[STAGES-1];
      sda_q <= sda_p[STAGES-1];
    end
  end

  assign scl_o      = scl_p[STAGES-1];
  assign sda_o      = sda_p[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/ee_i2c_addrctr.sv
module ee_i2c_addrctr #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_hi,
  input  logic [ADDR_W-9:0] hi_val,
  input  logic              load_lo,
  input  logic [7:0]        lo_val,
  input  logic              inc_page,
  input  logic              inc_lin,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int HI_W = ADDR_W - 8;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o <= '0;
    end else if (load_hi) begin
      addr_o[ADDR_W-1:8] <= hi_val;
    end else if (load_lo) begin
      addr_o[7:0] <= lo_val;
    end else if (inc_page) begin
      addr_o[PAGE_W-1:0] <= addr_o[PAGE_W-1:0] + 1'b1;
    end else if (inc_lin) begin
      addr_o <= addr_o + 1'b1;
    end
  end

  if (HI_W < 1) begin : g_bad_width
    initial $error("address width must exceed 8");
  end
endmodule

// File: rtl/ee_i2c_slave.sv
module ee_i2c_slave
  import ee_i2c_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int PAGE_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [2:0]        chip_sel_i,
  input  logic              busy_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              commit_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [7:0]        rd_data_i
);
  localparam int HI_W = ADDR_W - 8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
  phase_t ph, ph_after;
  logic [3:0] bitcnt;
  logic [BYTE_BITS-1:0] rxsh, txsh, txbuf;
  logic wrote, mack_ok;
  logic [ADDR_W-1:0] ctr;

  logic byte_end, cmd_hit, cmd_read;
  logic ld_hi, ld_lo, inc_pg, rd_fetch;

  ee_i2c_linecond #(.STAGES(SYNC_STAGES)) u_cond (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_c),
    .stop_o     (stop_c)
  );

  always_comb begin
    byte_end = scl_fall && (bitcnt == 4'd8);
    cmd_hit  = rxsh[7] && (rxsh[6:4] == chip_sel_i) && !busy_i;
    cmd_read = rxsh[0];
    ld_hi    = (ph == PH_CMD) && byte_end && cmd_hit && !cmd_read;
    ld_lo    = (ph == PH_ADDR) && byte_end;
    inc_pg   = (ph == PH_WDATA) && byte_end;
    rd_fetch = ((ph == PH_CMD) && byte_end && cmd_hit && cmd_read) ||
               ((ph == PH_MACK) && scl_rise && !sda_s);
  end

  ee_i2c_addrctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .load_hi  (ld_hi),
    .hi_val   (rxsh[HI_W:1]),
    .load_lo  (ld_lo),
    .lo_val   (rxsh),
    .inc_page (inc_pg),
    .inc_lin  (rd_fetch),
    .addr_o   (ctr)
  );

  always_ff @(posedge clk) begin
    if (rst) txbuf <= '0;
    else if (rd_ack_i) txbuf <= rd_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph         <= PH_IDLE;
      ph_after   <= PH_IDLE;
      bitcnt     <= '0;
      rxsh       <= '0;
      txsh       <= '0;
      wrote      <= 1'b0;
      mack_ok    <= 1'b0;
      sda_oe_o   <= 1'b0;
      wr_valid_o <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
      commit_o   <= 1'b0;
      rd_req_o   <= 1'b0;
      rd_addr_o  <= '0;
    end else begin
      wr_valid_o <= 1'b0;
      commit_o   <= 1'b0;
      rd_req_o   <= rd_fetch;
      if (rd_fetch) rd_addr_o <= ctr;
      if (start_c) begin
        ph       <= PH_CMD;
        bitcnt   <= '0;
        sda_oe_o <= 1'b0;
        wrote    <= 1'b0;
      end else if (stop_c) begin
        ph       <= PH_IDLE;
        bitcnt   <= '0;
        sda_oe_o <= 1'b0;
        commit_o <= wrote;
        wrote    <= 1'b0;
      end else begin
        case (ph)
          PH_CMD, PH_ADDR, PH_WDATA: begin
            if (scl_rise && bitcnt < 4'd8) begin
              rxsh   <= {rxsh[6:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end
            if (byte_end) begin
              if (ph == PH_CMD) begin
                if (cmd_hit) begin
                  sda_oe_o <= 1'b1;
                  ph       <= PH_ACK;
                  ph_after <= cmd_read ? PH_RDATA : PH_ADDR;
                end else begin
                  ph <= PH_SKIP;
                end
              end else begin
                sda_oe_o <= 1'b1;
                ph       <= PH_ACK;
                ph_after <= PH_WDATA;
                if (ph == PH_WDATA) begin
                  wr_valid_o <= 1'b1;
                  wr_addr_o  <= ctr;
                  wr_data_o  <= rxsh;
                  wrote      <= 1'b1;
                end
              end
            end
          end
          PH_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              ph     <= ph_after;
              if (ph_after == PH_RDATA) begin
                sda_oe_o <= ~txbuf[7];
                txsh     <= {txbuf[6:0], 1'b0};
              end else begin
                sda_oe_o <= 1'b0;
              end
            end
          end
          PH_RDATA: begin
            if (scl_rise) bitcnt <= bitcnt + 1'b1;
            if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe_o <= 1'b0;
                ph       <= PH_MACK;
              end else if (bitcnt != 4'd0) begin
                sda_oe_o <= ~txsh[7];
                txsh     <= {txsh[6:0], 1'b0};
              end
            end
          end
          PH_MACK: begin
            if (scl_rise) mack_ok <= !sda_s;
            if (scl_fall) begin
              if (mack_ok) begin
                ph       <= PH_RDATA;
                bitcnt   <= '0;
                sda_oe_o <= ~txbuf[7];
                txsh     <= {txbuf[6:0], 1'b0};
              end else begin
                ph <= PH_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ee_i2c_slave_chk.sv
module ee_i2c_slave_chk #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_s,
  input logic              start_c,
  input logic              stop_c,
  input logic              sda_oe_o,
  input logic              wr_valid_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic              rd_req_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              commit_o
);
  logic have_w, have_r;
  logic [ADDR_W-1:0] last_w, last_r;

  always_ff @(posedge clk) begin
    if (rst || start_c || stop_c) begin
      have_w <= 1'b0;
      have_r <= 1'b0;
      last_w <= '0;
      last_r <= '0;
    end else begin
      if (wr_valid_o) begin
        have_w <= 1'b1;
        last_w <= wr_addr_o;
      end
      if (rd_req_o) begin
        have_r <= 1'b1;
        last_r <= rd_addr_o;
      end
    end
  end

  p_rst_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sda_oe_o && !wr_valid_o && !rd_req_o && !commit_o));

  p_sda_moves_low_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe_o) |-> (!scl_s || $past(start_c || stop_c)));

  p_wr_single_r5: assert property (@(posedge clk) disable iff (rst)
    wr_valid_o |=> !wr_valid_o);

  p_page_stay_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_valid_o && have_w) |->
      (wr_addr_o[ADDR_W-1:PAGE_W] == last_w[ADDR_W-1:PAGE_W] &&
       wr_addr_o[PAGE_W-1:0] == last_w[PAGE_W-1:0] + 1'b1));

  p_commit_single_r6: assert property (@(posedge clk) disable iff (rst)
    commit_o |=> !commit_o);

  p_dir_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(wr_valid_o && rd_req_o));

  p_rd_step_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_req_o && have_r) |-> (rd_addr_o == last_r + 1'b1));
endmodule

bind ee_i2c_slave ee_i2c_slave_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .scl_s      (scl_s),
  .start_c    (start_c),
  .stop_c     (stop_c),
  .sda_oe_o   (sda_oe_o),
  .wr_valid_o (wr_valid_o),
  .wr_addr_o  (wr_addr_o),
  .rd_req_o   (rd_req_o),
  .rd_addr_o  (rd_addr_o),
  .commit_o   (commit_o)
);

// File: tb/ee_i2c_slave_test.sv
module ee_i2c_slave_test;
  localparam int Q = 8;
  localparam logic [2:0] CS = 3'b101;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic scl = 1'b1, sda_m = 1'b1, busy = 1'b0;
  logic sda_oe, wr_valid, commit, rd_req, rd_ack;
  logic [10:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  wire sda_bus = sda_m & ~sda_oe;

  ee_i2c_slave uut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .chip_sel_i(CS), .busy_i(busy), .wr_valid_o(wr_valid), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .commit_o(commit), .rd_req_o(rd_req), .rd_addr_o(rd_addr),
    .rd_ack_i(rd_ack), .rd_data_i(rd_data)
  );

  function automatic logic [7:0] memval(input logic [10:0] a);
    return 8'(a * 7 + 3) ^ 8'(a >> 3);
  endfunction

  int wn = 0, ncommit = 0;
  logic [10:0] wlog_a [0:63];
  logic [7:0]  wlog_d [0:63];
  always @(posedge clk) begin
    rd_ack <= 1'b0;
    if (rd_req) begin
      rd_ack  <= 1'b1;
      rd_data <= memval(rd_addr);
    end
    if (wr_valid) begin
      wlog_a[wn % 64] = wr_addr;
      wlog_d[wn % 64] = wr_data;
      wn = wn + 1;
    end
    if (commit) ncommit = ncommit + 1;
  end

  int nchk = 0, nerr = 0;
  bit finished = 0;
  logic [10:0] mctr = '0;
  logic [7:0] wbuf [0:31];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  task automatic waitq(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    if (!scl) begin
      waitq(); sda_m = 1'b1; waitq(); scl = 1'b1; waitq();
    end else begin
      sda_m = 1'b1; waitq();
    end
    sda_m = 1'b0; waitq(); scl = 1'b0;
  endtask

  task automatic bus_stop();
    waitq(); sda_m = 1'b0; waitq(); scl = 1'b1; waitq(); sda_m = 1'b1; waitq(2);
  endtask

  task automatic put_bit(input logic b);
    waitq(); sda_m = b; waitq(); scl = 1'b1; waitq(2); scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    waitq(); sda_m = 1'b1; waitq(); scl = 1'b1; waitq();
    ack = !sda_bus;
    waitq(); scl = 1'b0;
  endtask

  task automatic get_byte(input logic mack, output logic [7:0] d);
    sda_m = 1'b1;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      waitq(2); scl = 1'b1; waitq(); d = {d[6:0], sda_bus}; waitq(); scl = 1'b0;
    end
    waitq(); sda_m = ~mack; waitq(); scl = 1'b1; waitq(2); scl = 1'b0;
  endtask

  function automatic logic [7:0] wcmd(input logic [10:0] a);
    return {1'b1, CS, a[10:8], 1'b0};
  endfunction
  function automatic logic [7:0] rcmd();
    return {1'b1, CS, 3'b000, 1'b1};
  endfunction

  task automatic write_seq(input logic [10:0] a, input int n);
    logic ack;
    int w0, c0;
    w0 = wn; c0 = ncommit;
    bus_start();
    send_byte(wcmd(a), ack); chk("R4 write cmd ack", ack, 1);
    send_byte(a[7:0], ack);  chk("R4 addr ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], ack); chk("R5 data ack", ack, 1);
    end
    bus_stop();
    chk("R5 strobe count", wn - w0, n);
    for (int k = 0; k < n; k++) begin
      chk("R5 write addr", wlog_a[(w0 + k) % 64], {a[10:4], 4'(a[3:0] + k)});
      chk("R5 write data", wlog_d[(w0 + k) % 64], wbuf[k]);
    end
    chk("R6 commit count", ncommit - c0, (n > 0) ? 1 : 0);
    mctr = {a[10:4], 4'(a[3:0] + n)};
  endtask

  task automatic read_seq(input logic set_addr, input logic [10:0] a, input int n);
    logic ack;
    logic [7:0] d;
    logic [10:0] base;
    int c0;
    c0 = ncommit;
    bus_start();
    if (set_addr) begin
      send_byte(wcmd(a), ack); chk("R8 write cmd ack", ack, 1);
      send_byte(a[7:0], ack);  chk("R8 addr ack", ack, 1);
      bus_start();
      base = a;
    end else begin
      base = mctr;
    end
    send_byte(rcmd(), ack); chk("R7 read cmd ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      get_byte(k < n - 1, d);
      chk("R7 R8 R9 read data", d, memval(11'(base + k)));
    end
    waitq();
    chk("R7 released after nack", sda_oe, 0);
    bus_stop();
    chk("R6 no commit on read", ncommit - c0, 0);
    mctr = 11'(base + n);
  endtask

  initial begin
    repeat (3 * Q) @(negedge clk);
    wait (finished);
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    logic ack;
    logic [7:0] d;
    int w0, c0;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    chk("R1 sda released in reset", sda_oe, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 strobes idle", {wr_valid, rd_req, commit, sda_oe}, 0);

    read_seq(0, 11'h000, 1);

    // R2 wrong select bits, then following byte ignored
    bus_start();
    send_byte({1'b1, 3'b010, 3'b000, 1'b0}, ack); chk("R2 mismatch nack", ack, 0);
    send_byte(8'h00, ack); chk("R2 ignored byte nack", ack, 0);
    bus_stop();
    bus_start();
    send_byte({1'b0, CS, 3'b000, 1'b1}, ack); chk("R2 top bit zero nack", ack, 0);
    bus_stop();

    // R3 busy refuses both directions
    busy = 1'b1;
    bus_start(); send_byte(wcmd(11'h100), ack); chk("R3 busy write nack", ack, 0); bus_stop();
    bus_start(); send_byte(rcmd(), ack); chk("R3 busy read nack", ack, 0); bus_stop();
    busy = 1'b0;

    // R4 R5 R6 single byte write, page wrap write
    wbuf[0] = 8'hC3;
    write_seq(11'h5A3, 1);
    for (int k = 0; k < 4; k++) wbuf[k] = 8'(8'h10 + k);
    write_seq(11'h12E, 4);

    // R6 address only, no commit; then current read from loaded address (R8)
    c0 = ncommit;
    bus_start();
    send_byte(wcmd(11'h2B7), ack); send_byte(8'hB7, ack);
    bus_stop();
    chk("R6 address-only no commit", ncommit - c0, 0);
    mctr = 11'h2B7;
    read_seq(0, 11'h000, 1);

    // R8 random read then current-address continuation, R9 rollover
    read_seq(1, 11'h3C5, 2);
    read_seq(0, 11'h000, 1);
    read_seq(1, 11'h7FE, 4);

    // R10 START in middle of a byte
    bus_start();
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_start();
    send_byte(rcmd(), ack); chk("R10 cmd after mid-byte start", ack, 1);
    get_byte(1'b0, d); chk("R10 read after abort", d, memval(mctr));
    mctr = mctr + 1'b1;
    bus_stop();

    // R10 STOP in middle of a data byte: no strobe, no commit
    w0 = wn; c0 = ncommit;
    bus_start();
    send_byte(wcmd(11'h444), ack); send_byte(8'h44, ack);
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_stop();
    chk("R10 partial byte no strobe", wn - w0, 0);
    chk("R10 R6 partial byte no commit", ncommit - c0, 0);
    mctr = 11'h444;
    read_seq(0, 11'h000, 1);

    // constrained random writes and reads
    for (int t = 0; t < 5; t++) begin
      logic [10:0] a;
      int n;
      a = 11'($urandom % 2048);
      n = 1 + int'($urandom % 17);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      write_seq(a, n);
    end
    for (int t = 0; t < 6; t++) begin
      logic [10:0] a;
      a = 11'($urandom % 2048);
      read_seq(($urandom % 2) == 0, a, 1 + int'($urandom % 4));
    end

    report();
  end
endmodule